// File: doc/BRIEF.md
# Clockless Handshake Bus Target

This block is the target side of a simple bus that has no bus clock. Each transfer is a four-phase exchange on two active-low lines. The initiator places an address, a one-bit command and, for a write, the data. It then pulls its request line low. The target does its part and pulls its acknowledge line low. The initiator then raises request, and the target answers by raising acknowledge.

Two addresses are decoded. Address 0x04 is a read-only location that reports the level of a push-button. Address 0x05 is a one-bit write-only register that drives an LED. Any other address still completes the handshake: a read of it returns zero and a write to it changes nothing.

The target runs on a local clock that is used only to bring the incoming request, and the button, into its own domain. It does not drive the shared data lines directly. It presents read data on `data_out` and a tri-state enable on `data_oe`, and the pad logic outside the block combines these with `data_in`.

Top module: `hs_bus_target`

## Requirements
- R1: While reset is asserted and at the first clock after it is released, `ack_n` is 1, `data_oe` is 0 and `led` is 0.
- R2: `req_n` passes through two flops before it is used. The address, command and write data are taken on the third rising clock edge after `req_n` falls. `ack_n` falls only after the synchronised request has been seen low.
- R3: A command of 0 is a read. `data_out` becomes valid and `data_oe` rises at the capture edge, which is one clock before `ack_n` falls on the fourth edge.
- R4: A command of 1 is a write. A write to address 0x05 stores `data_in` bit 0 into `led` at the capture edge, which is before `ack_n` falls.
- R5: After `req_n` rises, `ack_n` returns to 1 and `data_oe` returns to 0 on the third rising edge. `ack_n` stays low for as long as the synchronised request stays low.
- R6: A read of address 0x04 returns 0x00 or 0x01, with bit 0 equal to the button level. The button passes through two flops before it is sampled.
- R7: `data_oe` is 1 only from the data-valid edge of a read until the release edge. It is never 1 during a write.
- R8: A read of any address other than 0x04 returns 0x00 and completes the full handshake.
- R9: A write to any address other than 0x05, including 0x04, leaves `led` unchanged and completes the full handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock used for synchronisation |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Request from the initiator, active low, asynchronous |
| cmd | input | 1 | 0 = read, 1 = write |
| addr | input | 8 | Transfer address |
| data_in | input | 8 | Data from the shared bus |
| data_out | output | 8 | Read data toward the bus pads |
| data_oe | output | 1 | Tri-state enable for `data_out` |
| ack_n | output | 1 | Acknowledge to the initiator, active low |
| button | input | 1 | Push-button level, asynchronous |
| led | output | 1 | LED register output |

## Verification
Two events can land in the same clock: the button can change in the very edge where a read of 0x04 takes its sample, and the initiator can lower a new request in the cycle right after acknowledge has returned high. The bench provokes the first by toggling the button a set number of cycles after `req_n` falls, at several offsets around the capture edge. It provokes the second by running transfers back to back with no idle gap. A behavioural model tracks the two-stage delay of both the request and the button, and it is compared with `ack_n`, `data_oe`, `data_out` and `led` on every clock. The model therefore judges exactly which button level should appear in the read.

// File: rtl/hs_bus_target.sv
module hs_bus_target #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] BTN_ADDR = 8'h04,
  parameter logic [AW-1:0] LED_ADDR = 8'h05
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_n,
  input  logic          cmd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          ack_n,
  input  logic          button,
  output logic          led
);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_HOLD} st_t;
  st_t st;

  logic [1:0] req_ff, btn_ff;
  logic req_s, btn_s, start;

  assign req_s = req_ff[1];
  assign btn_s = btn_ff[1];
  assign start = (st == S_IDLE) && !req_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ff <= 2'b11;
      btn_ff <= 2'b00;
    end else begin
      req_ff <= {req_ff[0], req_n};
      btn_ff <= {btn_ff[0], button};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ack_n    <= 1'b1;
      data_oe  <= 1'b0;
      data_out <= '0;
      led      <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_SETTLE;
          if (!cmd) begin
            data_oe  <= 1'b1;
            data_out <= (addr == BTN_ADDR) ? DW'(btn_s) : '0;
          end else if (addr == LED_ADDR) begin
            led <= data_in[0];
          end
        end
        S_SETTLE: begin
          ack_n <= 1'b0;
          st    <= S_HOLD;
        end
        S_HOLD: if (req_s) begin
          ack_n   <= 1'b1;
          data_oe <= 1'b0;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (ack_n && !data_oe && !led));
  a_r2_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(!req_s, 2));
  a_r3_data_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> ack_n);
  a_r5_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !req_s) |=> !ack_n);
  a_r5_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> !data_oe);
  a_r7_oe_not_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cmd) |=> !data_oe);
  a_r4_led_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(led));

endmodule

// File: tb/hs_bus_target_tb_top.sv
module hs_bus_target_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, req_n = 1'b1, cmd = 1'b0, button = 1'b0;
  logic [7:0] addr = 8'h00, data_in = 8'h00;
  logic [7:0] data_out;
  logic data_oe, ack_n, led;

  int tests = 0, fails = 0, cyc = 0;
  bit dog = 0;

  always #10 clk = ~clk;

  hs_bus_target dut_i (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .cmd(cmd), .addr(addr),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .ack_n(ack_n), .button(button), .led(led));

  // behavioural reference: queues hold the last two sampled request/button levels
  bit rq[$], bq[$];
  int phase = 0;
  logic e_ack = 1, e_oe = 0, e_led = 0;
  logic [7:0] e_dat = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rq = '{1, 1}; bq = '{0, 0}; phase = 0;
      e_ack = 1; e_oe = 0; e_led = 0; e_dat = 0;
    end else begin
      bit seen, bseen;
      seen = rq[0]; bseen = bq[0];
      if (phase == 0 && !seen) begin
        if (!cmd) begin e_oe = 1; e_dat = (addr == 8'h04) ? {7'b0, bseen} : 8'h00; end
        else if (addr == 8'h05) e_led = data_in[0];
        phase = 1;
      end else if (phase == 1) begin
        e_ack = 0; phase = 2;
      end else if (phase == 2 && seen) begin
        e_ack = 1; e_oe = 0; phase = 0;
      end
      void'(rq.pop_front()); rq.push_back(req_n);
      void'(bq.pop_front()); bq.push_back(button);
    end
  end

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %h expected %h", r, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 50000 && !dog) begin
      dog = 1; tests++; fails++;
      $display("FAIL watchdog expired at cycle %0d: got hang expected finish", cyc);
    end
    if (rst_n && cyc > 2) begin
      chk("R2/R5 ack_n", {7'b0, ack_n}, {7'b0, e_ack});
      chk("R7 data_oe", {7'b0, data_oe}, {7'b0, e_oe});
      chk("R4/R9 led", {7'b0, led}, {7'b0, e_led});
      if (e_oe) chk("R3/R6/R8 data_out", data_out, e_dat);
    end
  end

  task automatic wait_ack(logic lvl);
    while (ack_n !== lvl && !dog) @(negedge clk);
  endtask

  // toggle_at < 0: no button change; otherwise flip button that many cycles after req falls
  task automatic xfer(logic c, logic [7:0] a, logic [7:0] d, int toggle_at,
                      output logic [7:0] rd, input int gap);
    @(negedge clk);
    cmd = c; addr = a; data_in = d;
    @(negedge clk);
    req_n = 0;
    for (int i = 0; i < 6; i++) begin
      if (i == toggle_at) button = ~button;
      if (ack_n === 1'b0) break;
      @(negedge clk);
    end
    wait_ack(0);
    rd = data_out;
    req_n = 1;
    wait_ack(1);
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd;
    int k;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 ack_n", {7'b0, ack_n}, 8'h01);
    chk("R1 data_oe", {7'b0, data_oe}, 8'h00);
    chk("R1 led", {7'b0, led}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ack_n after release", {7'b0, ack_n}, 8'h01);

    // R2/R3: cycle timing of a read
    @(negedge clk); cmd = 0; addr = 8'h04; button = 1;
    repeat (3) @(negedge clk);
    req_n = 0;
    k = 0;
    while (ack_n === 1'b1 && k < 10) begin
      @(negedge clk); k++;
      if (k == 3) chk("R3 oe before ack", {6'b0, data_oe, ack_n}, 8'h03);
    end
    chk("R2 ack latency edges", k[7:0], 8'd4);
    chk("R6 button read 1", data_out, 8'h01);
    req_n = 1;
    k = 0;
    while (ack_n === 1'b0 && k < 10) begin @(negedge clk); k++; end
    chk("R5 release latency edges", k[7:0], 8'd3);
    chk("R5 oe off at release", {7'b0, data_oe}, 8'h00);
    repeat (3) @(negedge clk);

    button = 0; repeat (3) @(negedge clk);
    xfer(0, 8'h04, 8'h00, -1, rd, 2); chk("R6 button read 0", rd, 8'h00);
    xfer(1, 8'h05, 8'hA1, -1, rd, 2); chk("R4 led set", {7'b0, led}, 8'h01);
    xfer(1, 8'h05, 8'hFE, -1, rd, 2); chk("R4 led clear by bit0", {7'b0, led}, 8'h00);
    xfer(1, 8'h05, 8'h03, -1, rd, 2); chk("R4 led set again", {7'b0, led}, 8'h01);
    xfer(1, 8'h04, 8'h00, -1, rd, 2); chk("R9 write to button addr ignored", {7'b0, led}, 8'h01);
    xfer(1, 8'h85, 8'h00, -1, rd, 2); chk("R9 write to other addr ignored", {7'b0, led}, 8'h01);
    xfer(0, 8'h05, 8'h00, -1, rd, 2); chk("R8 read of write-only addr", rd, 8'h00);
    button = 1; repeat (3) @(negedge clk);
    xfer(0, 8'hFF, 8'h00, -1, rd, 2); chk("R8 read other addr", rd, 8'h00);
    xfer(0, 8'h84, 8'h00, -1, rd, 2); chk("R8 near-miss addr", rd, 8'h00);

    // R6: button edge near the sampling edge; model judges exact value
    for (int t = 0; t < 4; t++) xfer(0, 8'h04, 8'h00, t, rd, 3);

    // back-to-back transfers with no idle gap
    for (int j = 0; j < 8; j++) begin
      xfer(j[0], j[1] ? 8'h05 : 8'h04, {7'b0, j[2]}, -1, rd, 0);
      if (j[0] && j[1]) chk("R4 back-to-back led", {7'b0, led}, {7'b0, j[2]});
    end
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (dog);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule